// File: doc/BRIEF.md
# Bus-width matching port

This block is the adapter that sits in front of the second data port of a dual-port memory whose stored word is 36 bits wide, split into four 9-bit lanes. An external bus reaches the memory through it as full 36-bit long-words, as 18-bit halves or as single 9-bit lanes. Two configuration pins choose the width. They are wired once and left alone while the device runs. A fourth setting of the pins shuts off every data output of the port while the port is still selected. In that setting an access moves no data, which allows a select-independent handshake such as a semaphore access.

In the narrow widths, a half-select input and a lane-select input act as extra low-order address bits. On a write, the narrow data presented on the low pins is copied onto the chosen lanes, and a write enable is raised only for those lanes. The other lanes of the stored word keep their contents. On a read, the memory answers one cycle after the request. The adapter then places the chosen lanes on the low pins and raises a per-pin output enable only for the pins that carry data, so the pad ring leaves every other pin in high impedance. The output enables are registered together with the read-lane selection, so enables and data line up in the same cycle.

Top module: `busmatch_port`

## Requirements
- R1: With `cfg_narrow`=0 and `cfg_size`=0 (long-word), a write raises all four lane enables in `mem_we` and passes `bus_wdata` unchanged to `mem_wdata`; `bus_wsel` and `bus_bsel` have no effect.
- R2: In long-word mode, a read returns the whole stored word on `bus_rdata` in the cycle after the request, with all 36 bits of `bus_oe` high, whatever `bus_wsel` and `bus_bsel` are.
- R3: With `cfg_narrow`=1 and `cfg_size`=0 (half mode), a write stores `bus_wdata[17:0]` into bits 18–35 when `bus_wsel`=1 (lane enables 4'b1100) or into bits 0–17 when `bus_wsel`=0 (lane enables 4'b0011); the other half keeps its contents and `bus_bsel` has no effect.
- R4: In half mode, a read returns the selected half on `bus_rdata[17:0]` one cycle after the request, with `bus_oe[17:0]` high and `bus_oe[35:18]` low.
- R5: With `cfg_narrow`=1 and `cfg_size`=1 (lane mode), a write stores `bus_wdata[8:0]` into lane {`bus_wsel`,`bus_bsel`}: 0 is bits 0–8, 1 is bits 9–17, 2 is bits 18–26 and 3 is bits 27–35; exactly one bit of `mem_we` is raised and the other lanes keep their contents.
- R6: In lane mode, a read returns the selected lane on `bus_rdata[8:0]` one cycle after the request, with `bus_oe[8:0]` high and `bus_oe[35:9]` low.
- R7: With `cfg_narrow`=0 and `cfg_size`=1 (port off), no bit of `mem_we` and not `mem_re` is ever raised, whatever `bus_en` and `bus_we` are; `bus_oe` is all low in the following cycle, and the stored words are unchanged.
- R8: In the cycle after any cycle that issued no read, `bus_oe` is all low; `bus_rdata` is zero on every pin whose `bus_oe` bit is low.
- R9: While reset is held and until the first read, `bus_oe` and `bus_rdata` are zero, and with `bus_en` low no lane enable is raised.
- R10: `mem_addr` equals `bus_addr` in the cycle of each request, and `mem_re` is raised exactly in the cycles of read requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_narrow | input | 1 | Static width pin: 0 selects long-word or port-off, 1 selects a narrow width |
| cfg_size | input | 1 | Static size pin: selects lane or half when narrow, port-off when not narrow |
| bus_en | input | 1 | Port select, active high |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Word address |
| bus_wsel | input | 1 | Half select, also upper bit of the lane number |
| bus_bsel | input | 1 | Lower bit of the lane number |
| bus_wdata | input | 4*LANE_W | Write data from the pins |
| bus_rdata | output | 4*LANE_W | Read data toward the pins, zero where not enabled |
| bus_oe | output | 4*LANE_W | Per-pin output enable for the pad drivers |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 4*LANE_W | Memory write data, lanes steered |
| mem_we | output | 4 | Per-lane memory write enable |
| mem_re | output | 1 | Memory read request |
| mem_rdata | input | 4*LANE_W | Memory read data, valid one cycle after `mem_re` |

## Verification
The bench builds the block with 9-bit lanes and a 4-bit address, so a 16-word model memory lets it write and read back every address in every width. In half and lane modes it visits every select combination at every address, and it computes each expected word arithmetically from a reference copy of the memory. Because each narrow write is followed by reads of all the other halves and lanes, the bench shows that the untouched lanes keep their data. The port-off setting is checked at the memory interface and then confirmed by re-reading the whole memory in long-word mode.

// File: rtl/busmatch_pkg.sv
package busmatch_pkg;

  // Four lanes make up one stored word; the select decode depends on this.
  localparam int BM_LANES = 4;
  localparam int BM_SEL_W = 2;

  // Encoding is {cfg_narrow, cfg_size}.
  typedef enum logic [1:0] {
    BM_LONG = 2'b00,
    BM_OFF  = 2'b01,
    BM_HALF = 2'b10,
    BM_LANE = 2'b11
  } bm_mode_e;

  function automatic bm_mode_e bm_decode(input logic narrow, input logic size);
    return bm_mode_e'({narrow, size});
  endfunction

endpackage

// File: rtl/bm_rst_sync.sv
module bm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/bm_write_steer.sv
module bm_write_steer
  import busmatch_pkg::*;
#(
  parameter int LANE_W = 9
) (
  input  bm_mode_e                      mode,
  input  logic                          wr_go,
  input  logic                          wsel,
  input  logic                          bsel,
  input  logic [BM_LANES*LANE_W-1:0]    wdata,
  output logic [BM_LANES*LANE_W-1:0]    mem_wdata,
  output logic [BM_LANES-1:0]           mem_we
);

  for (genvar g = 0; g < BM_LANES; g++) begin : g_lane
    localparam logic [BM_SEL_W-1:0] LIDX = BM_SEL_W'(g);
    localparam int HOFF = (g % 2) * LANE_W;

    logic [LANE_W-1:0] lane_wd;
    logic              hit;

    always_comb begin
      lane_wd = '0;
      hit     = 1'b0;
      case (mode)
        BM_LONG: begin
          lane_wd = wdata[g*LANE_W +: LANE_W];
          hit     = 1'b1;
        end
        BM_HALF: begin
          lane_wd = wdata[HOFF +: LANE_W];
          hit     = (wsel == LIDX[1]);
        end
        BM_LANE: begin
          lane_wd = wdata[0 +: LANE_W];
          hit     = ({wsel, bsel} == LIDX);
        end
        default: begin
          lane_wd = '0;
          hit     = 1'b0;
        end
      endcase
    end

    assign mem_wdata[g*LANE_W +: LANE_W] = lane_wd;
    assign mem_we[g]                     = wr_go & hit;
  end

endmodule

// File: rtl/bm_read_steer.sv
module bm_read_steer
  import busmatch_pkg::*;
#(
  parameter int LANE_W = 9
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_go,
  input  bm_mode_e                      mode,
  input  logic                          wsel,
  input  logic                          bsel,
  input  logic [BM_LANES*LANE_W-1:0]    mem_rdata,
  output logic [BM_LANES*LANE_W-1:0]    bus_rdata,
  output logic [BM_LANES*LANE_W-1:0]    bus_oe
);

  localparam int DATA_W = BM_LANES * LANE_W;
  localparam int HALF_W = 2 * LANE_W;

  bm_mode_e              mode_q;
  logic [BM_SEL_W-1:0]   lane_q;
  logic [DATA_W-1:0]     oe_q;
  logic [DATA_W-1:0]     oe_d;
  logic [DATA_W-1:0]     pick;
  logic [LANE_W-1:0]     rd_lane [BM_LANES];

  // Next-state: enables for the pins that will carry the answer.
  always_comb begin
    oe_d = '0;
    if (rd_go) begin
      case (mode)
        BM_LONG: oe_d = '1;
        BM_HALF: oe_d[HALF_W-1:0] = '1;
        BM_LANE: oe_d[LANE_W-1:0] = '1;
        default: oe_d = '0;
      endcase
    end
  end

  // Registers; the selection is loaded only when a read is issued.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= '0;
      mode_q <= BM_LONG;
      lane_q <= '0;
    end else begin
      oe_q <= oe_d;
      if (rd_go) begin
        mode_q <= mode;
        lane_q <= {wsel, bsel};
      end
    end
  end

  for (genvar g = 0; g < BM_LANES; g++) begin : g_rd
    assign rd_lane[g] = mem_rdata[g*LANE_W +: LANE_W];
  end

  always_comb begin
    pick = '0;
    case (mode_q)
      BM_LONG: pick = mem_rdata;
      BM_HALF: pick[HALF_W-1:0] = lane_q[1] ? mem_rdata[DATA_W-1:HALF_W]
                                            : mem_rdata[HALF_W-1:0];
      BM_LANE: pick[LANE_W-1:0] = rd_lane[lane_q];
      default: pick = '0;
    endcase
  end

  assign bus_rdata = pick & oe_q;
  assign bus_oe    = oe_q;

endmodule

// File: rtl/busmatch_port.sv
module busmatch_port
  import busmatch_pkg::*;
#(
  parameter int LANE_W = 9,
  parameter int ADDR_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_narrow,
  input  logic                          cfg_size,
  input  logic                          bus_en,
  input  logic                          bus_we,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_wsel,
  input  logic                          bus_bsel,
  input  logic [BM_LANES*LANE_W-1:0]    bus_wdata,
  output logic [BM_LANES*LANE_W-1:0]    bus_rdata,
  output logic [BM_LANES*LANE_W-1:0]    bus_oe,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [BM_LANES*LANE_W-1:0]    mem_wdata,
  output logic [BM_LANES-1:0]           mem_we,
  output logic                          mem_re,
  input  logic [BM_LANES*LANE_W-1:0]    mem_rdata
);

  bm_mode_e mode;
  logic     port_live;
  logic     wr_go;
  logic     rd_go;
  logic     rst_core_n;

  bm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign mode      = bm_decode(cfg_narrow, cfg_size);
  assign port_live = bus_en && (mode != BM_OFF);
  assign wr_go     = port_live && bus_we;
  assign rd_go     = port_live && !bus_we;

  assign mem_addr = bus_addr;
  assign mem_re   = rd_go;

  bm_write_steer #(.LANE_W(LANE_W)) u_wr (
    .mode      (mode),
    .wr_go     (wr_go),
    .wsel      (bus_wsel),
    .bsel      (bus_bsel),
    .wdata     (bus_wdata),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we)
  );

  bm_read_steer #(.LANE_W(LANE_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .rd_go     (rd_go),
    .mode      (mode),
    .wsel      (bus_wsel),
    .bsel      (bus_bsel),
    .mem_rdata (mem_rdata),
    .bus_rdata (bus_rdata),
    .bus_oe    (bus_oe)
  );

endmodule

// File: rtl/busmatch_port_chk.sv
module busmatch_port_chk #(
  parameter int LANE_W = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_narrow,
  input logic                    cfg_size,
  input logic                    bus_en,
  input logic                    bus_we,
  input logic [4*LANE_W-1:0]     bus_rdata,
  input logic [4*LANE_W-1:0]     bus_oe,
  input logic [3:0]              mem_we,
  input logic                    mem_re
);

  localparam int DATA_W = 4 * LANE_W;
  localparam int HALF_W = 2 * LANE_W;
  localparam logic [DATA_W-1:0] OE_HALF = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
  localparam logic [DATA_W-1:0] OE_LANE = {{(DATA_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};

  logic port_off;
  logic rd_req;
  assign port_off = !cfg_narrow && cfg_size;
  assign rd_req   = bus_en && !bus_we && !port_off;

  // R1: a long-word write enables every lane
  assert_long_all_lanes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && !cfg_narrow && !cfg_size) |-> (&mem_we));

  // R2: a long-word read drives every pin next cycle
  assert_long_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && !cfg_narrow && !cfg_size) |=> (&bus_oe));

  // R3: a half write touches exactly two lanes
  assert_half_two_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && cfg_narrow && !cfg_size) |-> ($countones(mem_we) == 2));

  // R4: a half read drives only the low half
  assert_half_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && cfg_narrow && !cfg_size) |=> (bus_oe == OE_HALF));

  // R5: a lane write touches exactly one lane
  assert_lane_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && cfg_narrow && cfg_size) |-> ($countones(mem_we) == 1));

  // R6: a lane read drives only the low lane pins
  assert_lane_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && cfg_narrow && cfg_size) |=> (bus_oe == OE_LANE));

  // R7: port-off mode never reaches the memory
  assert_off_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    port_off |-> (mem_we == 4'b0000 && !mem_re));

  // R8: no read issued means no pin driven next cycle
  assert_idle_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> (bus_oe == '0));

  // R8: undriven pins carry zero data
  assert_masked_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rdata & ~bus_oe) == '0));

  // R10: a memory read request appears only for a read of a live port
  assert_read_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (bus_en && !bus_we && !port_off));

endmodule

bind busmatch_port busmatch_port_chk #(.LANE_W(LANE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .cfg_narrow (cfg_narrow),
  .cfg_size   (cfg_size),
  .bus_en     (bus_en),
  .bus_we     (bus_we),
  .bus_rdata  (bus_rdata),
  .bus_oe     (bus_oe),
  .mem_we     (mem_we),
  .mem_re     (mem_re)
);

// File: tb/busmatch_port_test.sv
`timescale 1ns/1ps
module busmatch_port_test;

  localparam int CLK_PERIOD = 10;
  localparam int LW    = 9;
  localparam int AW    = 4;
  localparam int DW    = 4 * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          cfg_narrow, cfg_size;
  logic          bus_en, bus_we, bus_wsel, bus_bsel;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata, bus_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [3:0]    mem_we;
  logic          mem_re;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;

  logic [DW-1:0] ram     [DEPTH];
  logic [DW-1:0] ref_mem [DEPTH];

  busmatch_port #(.LANE_W(LW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_narrow(cfg_narrow), .cfg_size(cfg_size),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wsel(bus_wsel), .bus_bsel(bus_bsel), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_oe(bus_oe), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Model memory: per-lane writes, one-cycle read latency.
  initial mem_rdata = '0;
  always @(posedge clk) begin
    for (int l = 0; l < 4; l++)
      if (mem_we[l]) ram[mem_addr][l*LW +: LW] <= mem_wdata[l*LW +: LW];
    if (mem_re) mem_rdata <= ram[mem_addr];
  end

  task automatic report;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements) act=%0d exp=<100000 cycles", cyc);
      report();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int s);
    logic [63:0] x;
    x = 64'(s + 7) * 64'h9E3779B97F4A7C15;
    return x[59:24];
  endfunction

  function automatic logic [DW-1:0] oe_for(input logic [1:0] m);
    case (m)
      2'b00: return '1;
      2'b10: return {{(2*LW){1'b0}}, {(2*LW){1'b1}}};
      2'b11: return {{(3*LW){1'b0}}, {LW{1'b1}}};
      default: return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] rd_for(input logic [1:0] m, input int a,
                                           input bit wa, input bit ba);
    logic [DW-1:0] r;
    r = '0;
    case (m)
      2'b00: r = ref_mem[a];
      2'b10: r[2*LW-1:0] = ref_mem[a][(wa ? 2*LW : 0) +: 2*LW];
      2'b11: r[LW-1:0]   = ref_mem[a][(2*wa + ba)*LW +: LW];
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [3:0] we_for(input logic [1:0] m, input bit wa, input bit ba);
    case (m)
      2'b00: return 4'b1111;
      2'b10: return wa ? 4'b1100 : 4'b0011;
      2'b11: return 4'b0001 << (2*wa + ba);
      default: return 4'b0000;
    endcase
  endfunction

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    {cfg_narrow, cfg_size} = m;
  endtask

  task automatic do_wr(input int a, input bit wa, input bit ba,
                       input logic [DW-1:0] d, input string req);
    logic [1:0] m;
    m = {cfg_narrow, cfg_size};
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = AW'(a);
    bus_wsel = wa; bus_bsel = ba; bus_wdata = d;
    #1;
    check(mem_we == we_for(m, wa, ba), req, DW'(mem_we), DW'(we_for(m, wa, ba)));
    check(mem_addr == AW'(a) && !mem_re, "R10", DW'({mem_re, mem_addr}), DW'(a));
    case (m)
      2'b00: ref_mem[a] = d;
      2'b10: ref_mem[a][(wa ? 2*LW : 0) +: 2*LW] = d[2*LW-1:0];
      2'b11: ref_mem[a][(2*wa + ba)*LW +: LW] = d[LW-1:0];
      default: ;
    endcase
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic do_rd(input int a, input bit wa, input bit ba, input string req);
    logic [1:0]    m;
    logic [DW-1:0] ed, eo;
    m  = {cfg_narrow, cfg_size};
    ed = rd_for(m, a, wa, ba);
    eo = oe_for(m);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = AW'(a);
    bus_wsel = wa; bus_bsel = ba;
    #1;
    check(mem_addr == AW'(a) && mem_re == (m != 2'b01), "R10",
          DW'({mem_re, mem_addr}), DW'(a));
    @(negedge clk);
    bus_en = 1'b0;
    check(bus_rdata == ed, req, bus_rdata, ed);
    check(bus_oe == eo, req, bus_oe, eo);
    @(negedge clk);
    check(bus_oe == '0 && bus_rdata == '0, "R8", bus_oe | bus_rdata, '0);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_narrow = 1'b0; cfg_size = 1'b0;
    bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_wsel = 1'b0; bus_bsel = 1'b0; bus_wdata = '0;

    // R9: reset state
    repeat (3) @(negedge clk);
    check(bus_oe == '0, "R9", bus_oe, '0);
    check(bus_rdata == '0, "R9", bus_rdata, '0);
    check(mem_we == 4'b0000, "R9", DW'(mem_we), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(bus_oe == '0 && bus_rdata == '0, "R9", bus_oe | bus_rdata, '0);

    // R1/R2: long-word fill and read-back with selects varied
    set_mode(2'b00);
    for (int a = 0; a < DEPTH; a++) do_wr(a, a[0], a[1], pat(a), "R1");
    for (int a = 0; a < DEPTH; a++) do_rd(a, a[1], a[0], "R2");

    // R3/R4: half writes with bsel toggled, read both halves
    set_mode(2'b10);
    for (int a = 0; a < DEPTH; a++) do_wr(a, a[0], a[2], pat(100 + a), "R3");
    for (int a = 0; a < DEPTH; a++)
      for (int h = 0; h < 2; h++) do_rd(a, h[0], a[1], "R4");

    // R5/R6: one lane per address, then read every lane
    set_mode(2'b11);
    for (int a = 0; a < DEPTH; a++) do_wr(a, a[1], a[0], pat(200 + a), "R5");
    for (int a = 0; a < DEPTH; a++)
      for (int l = 0; l < 4; l++) do_rd(a, l[1], l[0], "R6");

    // R7: port-off writes and reads
    set_mode(2'b01);
    for (int a = 0; a < DEPTH; a += 3) begin
      do_wr(a, a[0], a[1], pat(300 + a), "R7");
      do_rd(a, a[1], a[0], "R7");
    end

    // R7: memory unchanged, read back in long-word mode
    set_mode(2'b00);
    for (int a = 0; a < DEPTH; a++) do_rd(a, 1'b1, 1'b1, "R7");

    repeat (2) @(negedge clk);
    report();
    $finish;
  end

endmodule